// File: doc/BRIEF.md
# Flash Status Register Protection Logic

This block holds the protection state of a serial flash device's status register and rules on every decoded command. A command decoder upstream presents a single-cycle strobe with a command class, a target address and one byte of write data. One clock later the block answers with a registered accept or reject. It also updates its own state: the write-enable latch, the block-protect field, the register lock and the pin-disable bit. The memory array uses the verdict to start or skip the program or erase. The serial shifter reads the status byte whenever it likes.

The register lock has two roles. In normal operation it works with the external write-protect pin. When the lock is set and the pin is low, the device enters a hardware-protected state in which status writes are refused. In OTP mode the same bit is a one-way lock on the OTP sector. A status write in that mode ignores its data and sets the lock for good. A pin-disable bit lets the board leave the write-protect and hold pins floating: when it is set, both pins are ignored.

Commands are plain control strobes with no back-pressure. The block takes one command per cycle, back to back, and always answers exactly one cycle later. The status byte is a direct register output with no handshake.

Top module: `sr_protect`

## Requirements
- R1: The status byte is laid out as follows. Bit 7 is the lock, bit 6 is pin-disable, bits 5:2 are the block-protect field BP, bit 1 is the write-enable latch and bit 0 is 0. Reset clears it to 0x00. It is a register output, valid in every cycle and stable between commands.
- R2: Each strobe raises resp_valid in the next cycle only, with resp_accept giving the verdict on the state the block held before that strobe. With no strobe, both outputs stay low.
- R3: The command classes are encoded as 0 = write-disable, 1 = write-enable, 2 = status write, 3 = page program, 4 = sector erase, 5 = half-block erase, 6 = block erase and 7 = chip erase. Write-enable sets the latch and every other class clears it. Classes 2 to 7 are rejected while the latch is 0. Classes 0 and 1 are always accepted.
- R4: The hardware-protected state holds when all four of these are true: the lock is 1, wp_n is low, pin-disable is 0 and OTP mode is off. In that state every status write is rejected and bits 7:2 keep their value.
- R5: Outside OTP mode, an accepted status write loads the lock, pin-disable and BP from data bits 7, 6 and 5:2.
- R6: Outside OTP mode, classes 3 to 6 are rejected when the target block falls in the protected region. The block number is the top 6 address bits of a 64-block array. BP = 0 protects nothing. Any other BP value protects the top 2^(BP-1) blocks, which covers the whole array when BP is 7 or more.
- R7: Chip erase is accepted only outside OTP mode and only when BP is 0.
- R8: wp_active is high exactly when wp_n is low and pin-disable is 0. hold_active is high exactly when hold_n is low and pin-disable is 0.
- R9: In OTP mode, classes 3 to 6 are accepted when the lock is 0 and rejected when it is 1, whatever BP holds.
- R10: In OTP mode, an accepted status write discards its data and sets only the lock bit.
- R11: Once a status write in OTP mode has set the lock, it reads 1 until reset, whatever commands follow, including status writes after leaving OTP mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (factory state) |
| cmd_valid | input | 1 | Single-cycle decoded command strobe |
| cmd_class | input | 3 | Command class, encoded as in R3 |
| cmd_addr | input | ADDR_W | Target byte address |
| cmd_data | input | 8 | Status-write data byte |
| wp_n | input | 1 | External write-protect pin, active low |
| hold_n | input | 1 | External hold pin, active low |
| otp_mode | input | 1 | OTP mode flag |
| status_q | output | 8 | Status register byte |
| resp_valid | output | 1 | Verdict valid, one cycle after the strobe |
| resp_accept | output | 1 | Command accepted when high |
| wp_active | output | 1 | Effective write-protect enable |
| hold_active | output | 1 | Effective hold enable |

## Verification
The bench builds the block with a 12-bit address and the default 64 blocks. This places each block at a 64-byte step, so the first and last block of every protected region can be addressed directly. BP values 1, 3, 7 and 15 are used, which covers the one-block case, an interior boundary, and both ways of saturating to the whole array. The OTP sequence runs last because the lock it sets can only be cleared by reset.

// File: rtl/sr_protect_pkg.sv
package sr_protect_pkg;
  typedef enum logic [2:0] {
    CMD_WRDIS = 3'd0,
    CMD_WREN  = 3'd1,
    CMD_WSTAT = 3'd2,
    CMD_PROG  = 3'd3,
    CMD_SERA  = 3'd4,
    CMD_HERA  = 3'd5,
    CMD_BERA  = 3'd6,
    CMD_CERA  = 3'd7
  } cmd_e;

  localparam int LOCK_BIT = 7;
  localparam int PDIS_BIT = 6;
  localparam int BP_MSB   = 5;
  localparam int BP_LSB   = 2;
  localparam int WEL_BIT  = 1;
endpackage

// File: rtl/sr_region.sv
module sr_region #(
  parameter int BLK_LOG2 = 6
) (
  input  logic [BLK_LOG2-1:0] blk,
  input  logic [3:0]          bp,
  output logic                in_region
);
  localparam int NBLK = 1 << BLK_LOG2;

  // A block lies in the top 2^(bp-1) blocks when adding the span reaches NBLK.
  always_comb begin
    if (bp == 4'd0) in_region = 1'b0;
    else in_region = (int'(blk) + (1 << (int'(bp) - 1))) >= NBLK;
  end
endmodule

// File: rtl/sr_decide.sv
module sr_decide
  import sr_protect_pkg::*;
(
  input  cmd_e        cls,
  input  logic        wel,
  input  logic        lock,
  input  logic [3:0]  bp,
  input  logic        hw_prot,
  input  logic        otp_mode,
  input  logic        in_region,
  output logic        accept
);
  always_comb begin
    unique case (cls)
      CMD_WRDIS, CMD_WREN: accept = 1'b1;
      CMD_WSTAT:           accept = wel & (otp_mode | ~hw_prot);
      CMD_PROG, CMD_SERA, CMD_HERA, CMD_BERA:
        accept = wel & (otp_mode ? ~lock : ~in_region);
      CMD_CERA:            accept = wel & ~otp_mode & (bp == 4'd0);
      default:             accept = 1'b0;
    endcase
  end
endmodule

// File: rtl/sr_protect.sv
module sr_protect
  import sr_protect_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int BLK_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_class,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              wp_n,
  input  logic              hold_n,
  input  logic              otp_mode,
  output logic [7:0]        status_q,
  output logic              resp_valid,
  output logic              resp_accept,
  output logic              wp_active,
  output logic              hold_active
);
  logic       srp_q, fused_q, pdis_q, wel_q;
  logic [3:0] bp_q;
  logic       lock_eff, hw_prot, in_region, accept;
  logic [BLK_LOG2-1:0] blk;
  cmd_e       cls;

  assign cls      = cmd_e'(cmd_class);
  assign blk      = cmd_addr[ADDR_W-1 -: BLK_LOG2];
  assign lock_eff = srp_q | fused_q;
  assign wp_active   = ~pdis_q & ~wp_n;
  assign hold_active = ~pdis_q & ~hold_n;
  assign hw_prot  = lock_eff & wp_active & ~otp_mode;

  sr_region #(.BLK_LOG2(BLK_LOG2)) u_region (
    .blk       (blk),
    .bp        (bp_q),
    .in_region (in_region)
  );

  sr_decide u_decide (
    .cls       (cls),
    .wel       (wel_q),
    .lock      (lock_eff),
    .bp        (bp_q),
    .hw_prot   (hw_prot),
    .otp_mode  (otp_mode),
    .in_region (in_region),
    .accept    (accept)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srp_q       <= 1'b0;
      fused_q     <= 1'b0;
      pdis_q      <= 1'b0;
      bp_q        <= 4'd0;
      wel_q       <= 1'b0;
      resp_valid  <= 1'b0;
      resp_accept <= 1'b0;
    end else begin
      resp_valid  <= cmd_valid;
      resp_accept <= cmd_valid & accept;
      if (cmd_valid) begin
        wel_q <= (cls == CMD_WREN);
        if (accept && cls == CMD_WSTAT) begin
          if (otp_mode) begin
            fused_q <= 1'b1;
          end else begin
            srp_q  <= cmd_data[LOCK_BIT];
            pdis_q <= cmd_data[PDIS_BIT];
            bp_q   <= cmd_data[BP_MSB:BP_LSB];
          end
        end
      end
    end
  end

  assign status_q = {lock_eff, pdis_q, bp_q, wel_q, 1'b0};
endmodule

// File: rtl/sr_protect_chk.sv
module sr_protect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_class,
  input logic       wp_n,
  input logic       otp_mode,
  input logic [7:0] status_q,
  input logic       resp_valid,
  input logic       resp_accept,
  input logic       wp_active,
  input logic       hold_active
);
  a_r2_resp_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> resp_valid);
  a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!resp_valid && !resp_accept));
  a_r3_wel_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_class >= 3'd2 && !status_q[1]) |=> !resp_accept);
  a_r3_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_class != 3'd1) |=> !status_q[1]);
  a_r4_hw_prot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_class == 3'd2 && !otp_mode && status_q[7] && !status_q[6] && !wp_n)
    |=> (!resp_accept && $stable(status_q[7:2])));
  a_r7_chip_erase_bp: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_class == 3'd7 && status_q[5:2] != 4'd0) |=> !resp_accept);
  a_r8_pins_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[6] |-> (!wp_active && !hold_active));
  a_r11_lock_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (otp_mode && status_q[7]) |=> status_q[7]);
endmodule

bind sr_protect sr_protect_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_class   (cmd_class),
  .wp_n        (wp_n),
  .otp_mode    (otp_mode),
  .status_q    (status_q),
  .resp_valid  (resp_valid),
  .resp_accept (resp_accept),
  .wp_active   (wp_active),
  .hold_active (hold_active)
);

// File: tb/sr_protect_tb.sv
module sr_protect_tb;
  localparam int AW = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_class = 3'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0] cmd_data = 8'h00;
  logic wp_n = 1'b1, hold_n = 1'b1, otp_mode = 1'b0;
  logic [7:0] status_q;
  logic resp_valid, resp_accept, wp_active, hold_active;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  sr_protect #(.ADDR_W(AW), .BLK_LOG2(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_class(cmd_class),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_n(wp_n), .hold_n(hold_n),
    .otp_mode(otp_mode), .status_q(status_q), .resp_valid(resp_valid),
    .resp_accept(resp_accept), .wp_active(wp_active), .hold_active(hold_active)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive one strobe at a falling edge, sample the verdict one edge later (R2).
  task automatic issue(input logic [2:0] c, input int blk, input logic [7:0] d,
                       output logic acc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_class = c; cmd_addr = AW'(blk << 6); cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R2 resp_valid", resp_valid, 1);
    acc = resp_accept;
  endtask

  task automatic wr_stat(input logic [7:0] d, output logic acc);
    logic a;
    issue(3'd1, 0, 8'h00, a);
    issue(3'd2, 0, d, acc);
  endtask

  task automatic t_reset;
    check("R1 reset status", status_q, 8'h00);
    check("R2 idle resp_valid", resp_valid, 0);
    check("R8 wp_active idle", wp_active, 0);
  endtask

  task automatic t_wel;
    logic a;
    issue(3'd3, 0, 8'h00, a);
    check("R3 program without latch", a, 0);
    issue(3'd1, 0, 8'h00, a);
    check("R3 write-enable accepted", a, 1);
    check("R1 latch visible bit1", status_q, 8'h02);
    issue(3'd0, 0, 8'h00, a);
    check("R3 write-disable clears", status_q, 8'h00);
    issue(3'd1, 0, 8'h00, a);
    issue(3'd3, 0, 8'h00, a);
    check("R3 program with latch", a, 1);
    check("R3 latch cleared after", status_q[1], 0);
    @(negedge clk);
    check("R2 valid drops", resp_valid, 0);
    check("R1 status stable", status_q, 8'h00);
  endtask

  task automatic t_region;
    logic a;
    wr_stat(8'h0C, a);
    check("R5 write BP=3", a, 1);
    check("R5 status after write", status_q, 8'h0C);
    issue(3'd1, 0, 0, a); issue(3'd3, 59, 0, a);
    check("R6 BP3 block59 open", a, 1);
    issue(3'd1, 0, 0, a); issue(3'd4, 60, 0, a);
    check("R6 BP3 block60 guarded", a, 0);
    issue(3'd1, 0, 0, a); issue(3'd7, 0, 0, a);
    check("R7 chip erase BP!=0", a, 0);
    wr_stat(8'h04, a);
    issue(3'd1, 0, 0, a); issue(3'd6, 63, 0, a);
    check("R6 BP1 block63 guarded", a, 0);
    issue(3'd1, 0, 0, a); issue(3'd5, 62, 0, a);
    check("R6 BP1 block62 open", a, 1);
    wr_stat(8'h1C, a);
    issue(3'd1, 0, 0, a); issue(3'd3, 0, 0, a);
    check("R6 BP7 whole array", a, 0);
    wr_stat(8'h3C, a);
    issue(3'd1, 0, 0, a); issue(3'd3, 0, 0, a);
    check("R6 BP15 whole array", a, 0);
    wr_stat(8'h00, a);
    issue(3'd1, 0, 0, a); issue(3'd7, 0, 0, a);
    check("R7 chip erase BP=0", a, 1);
  endtask

  task automatic t_hwprot;
    logic a;
    wr_stat(8'h80, a);
    check("R5 set lock", status_q, 8'h80);
    wp_n = 1'b0; hold_n = 1'b0;
    @(negedge clk);
    check("R8 wp_active pin low", wp_active, 1);
    check("R8 hold_active pin low", hold_active, 1);
    wr_stat(8'h00, a);
    check("R4 write refused", a, 0);
    check("R4 bits kept", status_q, 8'h80);
    wp_n = 1'b1;
    wr_stat(8'hC0, a);
    check("R4 pin high releases", a, 1);
    wp_n = 1'b0;
    @(negedge clk);
    check("R8 disabled wp", wp_active, 0);
    check("R8 disabled hold", hold_active, 0);
    wr_stat(8'h00, a);
    check("R8 floating pin no protect", a, 1);
    check("R5 cleared", status_q, 8'h00);
    wp_n = 1'b1; hold_n = 1'b1;
  endtask

  task automatic t_otp;
    logic a;
    wr_stat(8'h0C, a);
    otp_mode = 1'b1;
    issue(3'd1, 0, 0, a); issue(3'd3, 63, 0, a);
    check("R9 OTP program lock0 ignores BP", a, 1);
    issue(3'd1, 0, 0, a); issue(3'd7, 0, 0, a);
    check("R7 chip erase in OTP", a, 0);
    wr_stat(8'h00, a);
    check("R10 OTP write accepted", a, 1);
    check("R10 data discarded lock set", status_q, 8'h8C);
    issue(3'd1, 0, 0, a); issue(3'd4, 0, 0, a);
    check("R9 OTP erase locked", a, 0);
    otp_mode = 1'b0;
    wr_stat(8'h00, a);
    check("R5 write accepted outside OTP", a, 1);
    check("R11 lock persists", status_q, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_wel;
    t_region;
    t_hwprot;
    t_otp;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule